// File: doc/BRIEF.md
# Snooping MESI Line Coherence Controller

This block keeps the coherence state of every line in a small direct-mapped write-back cache that shares a snooping bus with other caches. Each line holds one tag, one data word and a state: Modified, Exclusive, Shared or Invalid. The processor side presents reads and writes and holds each request until a one-cycle completion strobe. The bus side raises requests with a valid/grant handshake and snoops transactions from other caches. On a snoop it drives its part of a wired-OR shared signal and offers dirty data for flush.

The Exclusive state is the point of the design. A read miss that finds no other sharer fills the line as Exclusive. A later write to that line turns it Modified with no bus traffic at all. Only a write to a Shared line pays for an upgrade broadcast.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: On reset every line is Invalid, so the first access to any address misses and raises a bus request; no bus request, completion, shared or flush output is active right after reset.
- R2: A processor read that hits a Shared, Exclusive or Modified line completes in the cycle it is presented, with no bus request, returns the stored word, and leaves the state unchanged.
- R3: A read miss issues a read request (busReqOp 0) for the processor address and returns the fill word. The line becomes Shared if busShared is high in the grant cycle, and Exclusive otherwise.
- R4: A processor write to an Exclusive or Modified line completes with no bus request and leaves the line Modified with the new word.
- R5: A processor write to a Shared line issues an upgrade request (busReqOp 2) for its address, then completes and leaves the line Modified.
- R6: A processor write miss issues a read-exclusive request (busReqOp 1), stores the written word and leaves the line Modified.
- R7: A snooped read-exclusive (snoopOp 1) or upgrade (snoopOp 2) that hits a valid line sets it Invalid. If the line was Modified, snoopFlushValid and its word appear in that same cycle. snoopSharedOut stays low.
- R8: A snooped read (snoopOp 0) that hits a valid line raises snoopSharedOut and leaves the line Shared. A Modified line also raises snoopFlushValid with its word. snoopOp 3, a tag mismatch or an Invalid line produce no response.
- R9: A miss whose victim is Modified first issues a write-back request (busReqOp 3) carrying the victim's address and word, and then the fill request. A clean victim is dropped without a write-back.
- R10: In any cycle with snoopValid high, the snooper owns the state array. A processor request presented then does not complete, and it completes in the first snoop-free cycle after.
- R11: Once raised, a bus request keeps valid, operation and address unchanged until the cycle of its grant.
- R12: If the line is snooped Invalid while an upgrade waits for the bus, the granted upgrade does not complete the write. The request is then retried as a read-exclusive miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present, held until cpuReady |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address: upper bits tag, lower INDEX_W bits line index |
| cpuWData | input | DATA_W | Write word |
| cpuReady | output | 1 | Request completes at this clock edge |
| cpuRData | output | DATA_W | Read word, valid with cpuReady on a read |
| busReqValid | output | 1 | Bus request pending |
| busReqOp | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| busReqAddr | output | ADDR_W | Request address (victim address for a write-back) |
| busReqData | output | DATA_W | Write-back word |
| busGrant | input | 1 | Bus completes the pending request this cycle |
| busShared | input | 1 | Wired-OR shared line from other caches, sampled at grant |
| busFillData | input | DATA_W | Fill word, valid at grant |
| snoopValid | input | 1 | Snooped transaction present (never together with busGrant) |
| snoopOp | input | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 none |
| snoopAddr | input | ADDR_W | Snooped address |
| snoopSharedOut | output | 1 | This cache's contribution to the shared line |
| snoopFlushValid | output | 1 | This cache supplies dirty data for the snoop |
| snoopFlushData | output | DATA_W | Flushed word |

## Verification
States are never read directly. Each line state is identified from outside by what it does next. A snooped read separates Modified (flush plus shared) from Exclusive or Shared (shared only) and from Invalid (silence). A processor write separates Exclusive (no bus) from Shared (upgrade). Read fills are tried with the shared line both high and low to tell Exclusive from Shared fills. Misses are tried with clean and dirty victims to show the write-back appears only when it is owed. Two timing patterns finish the set. A snoop collides with a processor request in one cycle, and a snoop invalidates a line while its upgrade waits for the bus.

// File: rtl/mesi_coh_pkg.sv
package mesi_coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2,
    LN_MOD = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BOP_RD    = 2'd0,
    BOP_RDX   = 2'd1,
    BOP_UPGR  = 2'd2,
    BOP_FLUSH = 2'd3
  } busOp_t;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_UPGR  = 2'd1,
    CS_FLUSH = 2'd2,
    CS_FILL  = 2'd3
  } ctrlState_t;

  // strobes from control to datapath; all writes target the processor index
  typedef struct packed {
    logic       lineWe;   // write newState
    lineState_t newState;
    logic       tagWe;    // load the processor tag
    logic       dataWe;   // load a word
    logic       useFill;  // word comes from the bus fill instead of the processor
  } dpStrobe_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snoopValid,
  input  logic [1:0]        snoopOp,
  input  logic [ADDR_W-1:0] snoopAddr,
  output lineState_t        cpuState,
  output logic              cpuHit,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] lineData,
  output logic [DATA_W-1:0] cpuRData,
  output logic              snoopSharedOut,
  output logic              snoopFlushValid,
  output logic [DATA_W-1:0] snoopFlushData
);
  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int LINES = 1 << INDEX_W;

  lineState_t        stateQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];

  logic [INDEX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0]   cpuTag, snpTag;
  logic               snpHit;
  lineState_t         snpNext;

  assign cpuIdx = cpuAddr[INDEX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:INDEX_W];
  assign snpIdx = snoopAddr[INDEX_W-1:0];
  assign snpTag = snoopAddr[ADDR_W-1:INDEX_W];

  // snoop lookup
  assign snpHit  = snoopValid && (snoopOp != BOP_FLUSH) &&
                   (stateQ[snpIdx] != LN_INV) && (tagQ[snpIdx] == snpTag);
  assign snpNext = (snoopOp == BOP_RD) ? LN_SHR : LN_INV;

  assign snoopSharedOut  = snpHit && (snoopOp == BOP_RD);
  assign snoopFlushValid = snpHit && (stateQ[snpIdx] == LN_MOD);
  assign snoopFlushData  = dataQ[snpIdx];

  // processor lookup
  assign cpuState    = stateQ[cpuIdx];
  assign cpuHit      = (stateQ[cpuIdx] != LN_INV) && (tagQ[cpuIdx] == cpuTag);
  assign victimDirty = (stateQ[cpuIdx] == LN_MOD) && (tagQ[cpuIdx] != cpuTag);
  assign victimAddr  = {tagQ[cpuIdx], cpuIdx};
  assign lineData    = dataQ[cpuIdx];
  assign cpuRData    = strobe.useFill ? fillData : dataQ[cpuIdx];

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic snpSel, cpuSel;
    assign snpSel = snpHit && (snpIdx == INDEX_W'(g));
    // snooper owns the line in its cycle
    assign cpuSel = !snpSel && (cpuIdx == INDEX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateQ[g] <= LN_INV;
        tagQ[g]   <= '0;
        dataQ[g]  <= '0;
      end else begin
        if (snpSel)                       stateQ[g] <= snpNext;
        else if (cpuSel && strobe.lineWe) stateQ[g] <= strobe.newState;
        if (cpuSel && strobe.tagWe)       tagQ[g]   <= cpuTag;
        if (cpuSel && strobe.dataWe)      dataQ[g]  <= strobe.useFill ? fillData : cpuWData;
      end
    end
  end

endmodule

// File: rtl/mesi_coh_ctrl.sv
module mesi_coh_ctrl
  import mesi_coh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReqValid,
  input  logic       cpuReqWrite,
  input  logic       snoopValid,
  input  logic       busGrant,
  input  logic       busShared,
  input  logic       cpuHit,
  input  lineState_t cpuState,
  input  logic       victimDirty,
  output dpStrobe_t  strobe,
  output logic       cpuReady,
  output logic       busReqValid,
  output logic [1:0] busReqOp,
  output logic       flushSel
);
  ctrlState_t curQ, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) curQ <= CS_IDLE;
    else       curQ <= nxt;
  end

  always_comb begin
    nxt         = curQ;
    strobe      = '0;
    cpuReady    = 1'b0;
    busReqValid = 1'b0;
    busReqOp    = BOP_RD;
    flushSel    = 1'b0;
    unique case (curQ)
      CS_IDLE: begin
        if (cpuReqValid && !snoopValid) begin
          if (cpuHit) begin
            if (!cpuReqWrite) begin
              cpuReady = 1'b1;
            end else if (cpuState == LN_SHR) begin
              nxt = CS_UPGR;
            end else begin
              strobe.lineWe   = 1'b1;
              strobe.newState = LN_MOD;
              strobe.dataWe   = 1'b1;
              cpuReady        = 1'b1;
            end
          end else if (victimDirty) begin
            nxt = CS_FLUSH;
          end else begin
            nxt = CS_FILL;
          end
        end
      end
      CS_UPGR: begin
        busReqValid = 1'b1;
        busReqOp    = BOP_UPGR;
        if (busGrant) begin
          nxt = CS_IDLE;
          // only complete if no snoop took the copy while waiting
          if (cpuHit && cpuState == LN_SHR) begin
            strobe.lineWe   = 1'b1;
            strobe.newState = LN_MOD;
            strobe.dataWe   = 1'b1;
            cpuReady        = 1'b1;
          end
        end
      end
      CS_FLUSH: begin
        busReqValid = 1'b1;
        busReqOp    = BOP_FLUSH;
        flushSel    = 1'b1;
        if (busGrant) begin
          strobe.lineWe   = 1'b1;
          strobe.newState = LN_INV;
          nxt             = CS_FILL;
        end
      end
      CS_FILL: begin
        busReqValid = 1'b1;
        busReqOp    = cpuReqWrite ? BOP_RDX : BOP_RD;
        if (busGrant) begin
          strobe.lineWe   = 1'b1;
          strobe.tagWe    = 1'b1;
          strobe.dataWe   = 1'b1;
          strobe.useFill  = !cpuReqWrite;
          strobe.newState = cpuReqWrite ? LN_MOD : (busShared ? LN_SHR : LN_EXC);
          cpuReady        = 1'b1;
          nxt             = CS_IDLE;
        end
      end
      default: nxt = CS_IDLE;
    endcase
  end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRData,
  output logic              busReqValid,
  output logic [1:0]        busReqOp,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busGrant,
  input  logic              busShared,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snoopValid,
  input  logic [1:0]        snoopOp,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              snoopSharedOut,
  output logic              snoopFlushValid,
  output logic [DATA_W-1:0] snoopFlushData
);
  dpStrobe_t         strobe;
  lineState_t        cpuState;
  logic              cpuHit, victimDirty, flushSel;
  logic [ADDR_W-1:0] victimAddr;
  logic [DATA_W-1:0] lineData;

  mesi_coh_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite),
    .snoopValid(snoopValid), .busGrant(busGrant), .busShared(busShared),
    .cpuHit(cpuHit), .cpuState(cpuState), .victimDirty(victimDirty),
    .strobe(strobe), .cpuReady(cpuReady),
    .busReqValid(busReqValid), .busReqOp(busReqOp), .flushSel(flushSel)
  );

  mesi_line_store #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData), .fillData(busFillData),
    .snoopValid(snoopValid), .snoopOp(snoopOp), .snoopAddr(snoopAddr),
    .cpuState(cpuState), .cpuHit(cpuHit), .victimDirty(victimDirty),
    .victimAddr(victimAddr), .lineData(lineData), .cpuRData(cpuRData),
    .snoopSharedOut(snoopSharedOut), .snoopFlushValid(snoopFlushValid),
    .snoopFlushData(snoopFlushData)
  );

  assign busReqAddr = flushSel ? victimAddr : cpuAddr;
  assign busReqData = lineData;

endmodule

// File: rtl/mesi_snoop_checker.sv
module mesi_snoop_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              busReqValid,
  input logic              busGrant,
  input logic [1:0]        busReqOp,
  input logic [ADDR_W-1:0] busReqAddr,
  input logic              snoopValid,
  input logic [1:0]        snoopOp,
  input logic              snoopSharedOut
);
  // R2/R4: a completion without a grant never has a bus request open
  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && !busGrant) |-> !busReqValid);

  // R8: shared is only driven for a snooped read
  a_r8_shared_on_read: assert property (@(posedge clk) disable iff (!rstN)
    snoopSharedOut |-> (snoopValid && snoopOp == 2'd0));

  // R9: a granted write-back is followed by the fill request
  a_r9_fill_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busGrant && busReqOp == 2'd3) |=>
      (busReqValid && (busReqOp == 2'd0 || busReqOp == 2'd1)));

  // R10: no completion in a snoop cycle
  a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid |-> !cpuReady);

  // R11: request held steady until granted
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busGrant) |=>
      (busReqValid && $stable(busReqOp) && $stable(busReqAddr)));
endmodule

bind mesi_snoop_ctrl mesi_snoop_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady),
  .busReqValid(busReqValid), .busGrant(busGrant), .busReqOp(busReqOp),
  .busReqAddr(busReqAddr), .snoopValid(snoopValid), .snoopOp(snoopOp),
  .snoopSharedOut(snoopSharedOut)
);

// File: tb/test_mesi_snoop_ctrl.sv
module test_mesi_snoop_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWData = '0;
  logic          cpuReady;
  logic [DW-1:0] cpuRData;
  logic          busReqValid;
  logic [1:0]    busReqOp;
  logic [AW-1:0] busReqAddr;
  logic [DW-1:0] busReqData;
  logic          busGrant = 1'b0, busShared = 1'b0;
  logic [DW-1:0] busFillData = '0;
  logic          snoopValid = 1'b0;
  logic [1:0]    snoopOp = 2'd3;
  logic [AW-1:0] snoopAddr = '0;
  logic          snoopSharedOut, snoopFlushValid;
  logic [DW-1:0] snoopFlushData;

  int checks = 0;
  int errors = 0;

  logic [1:0]    opLog   [4];
  logic [AW-1:0] addrLog [4];
  logic [DW-1:0] dataLog [4];
  int            nOps;
  logic [DW-1:0] lastRData;
  logic          snpSh, snpFl;
  logic [DW-1:0] snpFd;

  always #10 clk = ~clk;  // 50 MHz

  mesi_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(2), .DATA_W(DW)) i_mesi_snoop_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuReady(cpuReady), .cpuRData(cpuRData),
    .busReqValid(busReqValid), .busReqOp(busReqOp), .busReqAddr(busReqAddr),
    .busReqData(busReqData), .busGrant(busGrant), .busShared(busShared),
    .busFillData(busFillData), .snoopValid(snoopValid), .snoopOp(snoopOp),
    .snoopAddr(snoopAddr), .snoopSharedOut(snoopSharedOut),
    .snoopFlushValid(snoopFlushValid), .snoopFlushData(snoopFlushData)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // processor access; bus grants one cycle after each request appears
  task automatic cpuOp(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input logic sh, input logic [DW-1:0] fd);
    int waitCnt = 0;
    logic done = 1'b0;
    nOps = 0;
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = w; cpuAddr = a; cpuWData = wd;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      #1;
      busGrant = 1'b0;
      if (busReqValid) begin
        if (waitCnt >= 1) begin
          busGrant = 1'b1; busShared = sh; busFillData = fd;
          if (nOps < 4) begin
            opLog[nOps] = busReqOp; addrLog[nOps] = busReqAddr; dataLog[nOps] = busReqData;
          end
          nOps++;
          waitCnt = 0;
        end else waitCnt++;
      end
      #1;
      if (cpuReady) begin
        lastRData = cpuRData;
        done = 1'b1;
      end else @(negedge clk);
    end
    if (!done) begin
      errors++;
      $display("FAIL cpuOp: request to %0h never completed", a);
    end
    @(negedge clk);
    cpuReqValid = 1'b0; busGrant = 1'b0; busShared = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk);
    snoopValid = 1'b1; snoopOp = op; snoopAddr = a;
    #1;
    snpSh = snoopSharedOut; snpFl = snoopFlushValid; snpFd = snoopFlushData;
    @(negedge clk);
    snoopValid = 1'b0; snoopOp = 2'd3;
  endtask

  task automatic tReset();
    check("R1", "busReqValid after reset", busReqValid, 0);
    check("R1", "cpuReady after reset", cpuReady, 0);
    snoop(2'd0, 8'h01);
    check("R1", "snoop shared on empty cache", snpSh, 0);
    check("R1", "snoop flush on empty cache", snpFl, 0);
  endtask

  task automatic tReadMissHit();
    cpuOp(1'b0, 8'h01, 16'h0, 1'b0, 16'h1111);
    check("R3", "read miss bus ops", nOps, 1);
    check("R3", "read miss op", opLog[0], 0);
    check("R3", "read miss addr", addrLog[0], 8'h01);
    check("R3", "read miss data", lastRData, 16'h1111);
    cpuOp(1'b0, 8'h01, 16'h0, 1'b0, 16'hdead);
    check("R2", "read hit bus ops", nOps, 0);
    check("R2", "read hit data", lastRData, 16'h1111);
  endtask

  task automatic tExclusiveWrite();
    cpuOp(1'b1, 8'h01, 16'haaaa, 1'b0, 16'h0);
    check("R4", "write to E bus ops", nOps, 0);
    snoop(2'd0, 8'h01);
    check("R8", "M line snooped read flush", snpFl, 1);
    check("R8", "M line snooped read data", snpFd, 16'haaaa);
    check("R8", "M line snooped read shared", snpSh, 1);
  endtask

  task automatic tSharedWrite();
    cpuOp(1'b1, 8'h01, 16'hbbbb, 1'b0, 16'h0);
    check("R5", "write to S bus ops", nOps, 1);
    check("R5", "write to S op", opLog[0], 2);
    check("R5", "write to S addr", addrLog[0], 8'h01);
    snoop(2'd1, 8'h01);
    check("R7", "snooped rdx on M flush", snpFl, 1);
    check("R7", "snooped rdx on M data", snpFd, 16'hbbbb);
    check("R7", "snooped rdx shared", snpSh, 0);
    cpuOp(1'b0, 8'h01, 16'h0, 1'b1, 16'h4444);
    check("R7", "read after invalidation misses", nOps, 1);
    check("R3", "shared fill data", lastRData, 16'h4444);
    snoop(2'd0, 8'h01);
    check("R3", "shared fill answers shared", snpSh, 1);
    check("R3", "shared fill no flush", snpFl, 0);
    cpuOp(1'b1, 8'h01, 16'h5555, 1'b0, 16'h0);
    check("R3", "S fill needs upgrade", opLog[0], 2);
    snoop(2'd2, 8'h01);
    check("R7", "snooped upgrade on M flush", snpFl, 1);
    check("R7", "snooped upgrade on M data", snpFd, 16'h5555);
    cpuOp(1'b0, 8'h01, 16'h0, 1'b1, 16'h4444);
    check("R7", "read after upgrade snoop misses", nOps, 1);
  endtask

  task automatic tExclusiveSnoop();
    cpuOp(1'b0, 8'h02, 16'h0, 1'b0, 16'h2222);
    snoop(2'd3, 8'h02);
    check("R8", "snoop op 3 ignored", {snpSh, snpFl}, 0);
    snoop(2'd0, 8'h06);
    check("R8", "tag mismatch ignored", {snpSh, snpFl}, 0);
    snoop(2'd0, 8'h02);
    check("R8", "E line snooped read shared", snpSh, 1);
    check("R8", "E line snooped read no flush", snpFl, 0);
    cpuOp(1'b1, 8'h02, 16'h2222, 1'b0, 16'h0);
    check("R8", "E dropped to S needs upgrade", opLog[0], 2);
    snoop(2'd0, 8'h02);
    check("R4", "line M after upgrade", snpFl, 1);
  endtask

  task automatic tWriteMiss();
    cpuOp(1'b1, 8'h03, 16'h3333, 1'b0, 16'hffff);
    check("R6", "write miss bus ops", nOps, 1);
    check("R6", "write miss op", opLog[0], 1);
    snoop(2'd0, 8'h03);
    check("R6", "write miss leaves M", snpFl, 1);
    check("R6", "write miss stored word", snpFd, 16'h3333);
  endtask

  task automatic tVictim();
    cpuOp(1'b1, 8'h07, 16'h7777, 1'b0, 16'h0);
    check("R9", "clean victim no write-back", nOps, 1);
    check("R9", "clean victim op", opLog[0], 1);
    cpuOp(1'b0, 8'h0b, 16'h0, 1'b0, 16'hb0b0);
    check("R9", "dirty victim op count", nOps, 2);
    check("R9", "write-back first", opLog[0], 3);
    check("R9", "write-back addr", addrLog[0], 8'h07);
    check("R9", "write-back data", dataLog[0], 16'h7777);
    check("R9", "fill second", opLog[1], 0);
    check("R9", "fill addr", addrLog[1], 8'h0b);
    check("R9", "fill data returned", lastRData, 16'hb0b0);
    snoop(2'd0, 8'h07);
    check("R9", "victim gone", {snpSh, snpFl}, 0);
  endtask

  task automatic tSnoopPriority();
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b0; cpuAddr = 8'h02;
    snoopValid = 1'b1; snoopOp = 2'd0; snoopAddr = 8'h02;
    #1;
    check("R10", "cpu stalled in snoop cycle", cpuReady, 0);
    check("R10", "snoop answered", snoopSharedOut, 1);
    @(negedge clk);
    snoopValid = 1'b0; snoopOp = 2'd3;
    #1;
    check("R10", "cpu completes after snoop", cpuReady, 1);
    check("R10", "cpu data after snoop", cpuRData, 16'h2222);
    check("R10", "no bus request", busReqValid, 0);
    @(negedge clk);
    cpuReqValid = 1'b0;
  endtask

  task automatic tUpgradeRace();
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b1; cpuAddr = 8'h01; cpuWData = 16'hcccc;
    @(negedge clk);
    #1;
    check("R12", "upgrade requested", {busReqValid, busReqOp}, {1'b1, 2'd2});
    snoopValid = 1'b1; snoopOp = 2'd1; snoopAddr = 8'h01;
    #1;
    check("R12", "S line snooped rdx no flush", snoopFlushValid, 0);
    @(negedge clk);
    snoopValid = 1'b0; snoopOp = 2'd3;
    #1;
    check("R11", "upgrade still held", {busReqValid, busReqOp}, {1'b1, 2'd2});
    busGrant = 1'b1;
    #1;
    check("R12", "stale upgrade does not complete", cpuReady, 0);
    @(negedge clk);
    busGrant = 1'b0;
    #1;
    check("R12", "retry lookup cycle", busReqValid, 0);
    @(negedge clk);
    #1;
    check("R12", "retried as rdx", {busReqValid, busReqOp}, {1'b1, 2'd1});
    busGrant = 1'b1; busFillData = 16'h0bad;
    #1;
    check("R12", "rdx completes", cpuReady, 1);
    @(negedge clk);
    busGrant = 1'b0; cpuReqValid = 1'b0;
    snoop(2'd0, 8'h01);
    check("R12", "retried write stored", snpFd, 16'hcccc);
    check("R12", "retried write M", snpFl, 1);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    tReset();
    tReadMissHit();
    tExclusiveWrite();
    tSharedWrite();
    tExclusiveSnoop();
    tWriteMiss();
    tVictim();
    tSnoopPriority();
    tUpgradeRace();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule